// File: doc/BRIEF.md
# Indirect Interrupt Router Register Window

This block is the software-visible register front end of an interrupt router. A host on a simple register bus sees only two locations. A select byte at offset 0x00 picks one internal 32-bit register. A data window at offset 0x10 reads or writes the register that the select byte picks. The internal registers are:

- an identification register holding a 4-bit router ID;
- a read-only version register;
- a read-only arbitration register that mirrors the ID;
- a table of 64-bit redirection entries, one per input pin, reached one 32-bit half at a time.

The full redirection table is exported as a flat vector to the delivery logic. That logic can also raise the remote-pending flag of a level-triggered entry. Every accepted entry write produces a one-cycle pulse carrying the pin index. An entry write that flips the entry's mask bit produces a second pulse carrying the pin index and the new mask value.

Entry layout used throughout: vector in bits 7:0, delivery mode in 10:8, destination mode in bit 11, remote-pending in bit 14, trigger mode in bit 15 (1 = level), mask in bit 16, destination ID in bits 63:56.

Top module: `irq_regwin`

## Requirements
- R1: A write to offset 0x00 stores the low byte of the write data as the select value. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R2: With select 0x01, a window read returns (NPINS-1) in bits 23:16 and VER_CODE in bits 7:0, with all other bits zero. Window writes with this select change nothing.
- R3: With select 0x00, a window write stores write-data bits 27:24 as the ID. A window read returns the ID in bits 27:24 and zero elsewhere.
- R4: With select 0x02, a window read returns the same word as the ID read. Window writes with this select leave the ID unchanged.
- R5: For a select of 0x10 or above, the entry index is (select-0x10)>>1. An odd select reaches bits 63:32 of that entry and an even select reaches bits 31:0. The written half appears both in window reads and in the exported table, and the other half is left unchanged.
- R6: A window read returns all ones for two kinds of select: any select from 0x03 to 0x0F, and any entry index at or beyond NPINS. Window writes with such a select change no state and produce no pulse.
- R7: A write to the low half of an entry forces its remote-pending bit (bit 14) to 0, whatever the data holds. A write to the high half leaves the bit as it was.
- R8: A pulse on rp_set[i] sets bit 14 of entry i on the next clock only if the entry's bit 15 is 1. A low-half write to the same entry in the same cycle takes precedence and leaves bit 14 at 0.
- R9: After reset, every entry reads 0x0001_0000 in its low half (mask set) and 0 in its high half. The select value, the ID and both pulses are 0.
- R10: One cycle after a low-half write that changes an entry's bit 16, mask_chg is high for one cycle, with mask_chg_pin naming the pin and mask_chg_val giving the new bit. A write that leaves bit 16 unchanged raises no mask_chg.
- R11: One cycle after every in-range entry write (either half), ent_wr is high for one cycle, with ent_wr_pin naming the pin.
- R12: Reads of any offset other than 0x00 and 0x10 return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 8 | Byte offset inside the window block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| rp_set | input | NPINS | Per-pin request from delivery logic to set remote-pending |
| tbl_flat | output | NPINS*64 | Redirection table, entry i at bits i*64+63 down to i*64 |
| ent_wr | output | 1 | Entry-write pulse |
| ent_wr_pin | output | $clog2(NPINS) | Pin index of the entry-write pulse |
| mask_chg | output | 1 | Mask-change pulse |
| mask_chg_pin | output | $clog2(NPINS) | Pin index of the mask-change pulse |
| mask_chg_val | output | 1 | New mask bit carried with the mask-change pulse |

## Verification
The assertions assume that bus_wr and bus_rd are never undefined once reset is released. They also assume that rp_set is a pulse from the delivery side that may coincide with any bus write. They do not rely on the bus issuing only one access per cycle beyond what the port allows. The bench drives every input at the falling clock edge and holds reset low from time zero. It drives rp_set both alone and in the same cycle as a low-half write to the same pin, so the precedence rule is exercised inside the assumed input space.

// File: rtl/irw_pkg.sv
package irw_pkg;

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_ENT0 = 8'h10;

  localparam int B_RP   = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;

  localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    K_ID  = 3'd0,
    K_VER = 3'd1,
    K_ARB = 3'd2,
    K_ENT = 3'd3,
    K_BAD = 3'd4
  } reg_kind_t;

  function automatic logic [6:0] ent_index(input logic [7:0] sel);
    logic [7:0] off;
    off = sel - SEL_ENT0;
    return off[7:1];
  endfunction

  function automatic reg_kind_t classify(input logic [7:0] sel, input int npins);
    if (sel == SEL_ID)  return K_ID;
    if (sel == SEL_VER) return K_VER;
    if (sel == SEL_ARB) return K_ARB;
    if (sel >= SEL_ENT0 && int'(ent_index(sel)) < npins) return K_ENT;
    return K_BAD;
  endfunction

  function automatic logic [31:0] ver_word(input int npins, input logic [7:0] code);
    logic [7:0] top;
    top = 8'(npins - 1);
    return {8'h00, top, 8'h00, code};
  endfunction

  function automatic logic [31:0] id_word(input logic [3:0] id);
    return {4'h0, id, 24'h0};
  endfunction

endpackage

// File: rtl/irw_select.sv
module irw_select
  import irw_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic [7:0]      sel_wbyte,
  output logic [7:0]      sel_q,
  output reg_kind_t       kind,
  output logic [IDXW-1:0] idx,
  output logic            hi_half
);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= 8'h00;
    else if (sel_we) sel_q <= sel_wbyte;
  end

  logic [6:0] raw_idx;
  assign raw_idx = ent_index(sel_q);
  assign kind    = classify(sel_q, NPINS);
  assign idx     = IDXW'(raw_idx);
  assign hi_half = sel_q[0];

  // R1: the select register keeps exactly the low byte written
  p_sel_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_q == $past(sel_wbyte));

  p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_q));

endmodule

// File: rtl/irw_table.sv
module irw_table
  import irw_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDXW-1:0]    widx,
  input  logic               whi,
  input  logic [31:0]        wdata,
  input  logic [NPINS-1:0]   rp_set,
  output logic [NPINS*64-1:0] tbl,
  output logic               ent_wr,
  output logic [IDXW-1:0]    ent_wr_pin,
  output logic               mask_chg,
  output logic [IDXW-1:0]    mask_chg_pin,
  output logic               mask_chg_val
);

  logic [NPINS-1:0][63:0] ent_q;
  logic [NPINS-1:0][63:0] ent_d;
  logic [NPINS-1:0]       hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign hit[i] = we && (widx == IDXW'(i));

    always_comb begin
      ent_d[i] = ent_q[i];
      if (rp_set[i] && ent_q[i][B_TRIG]) ent_d[i][B_RP] = 1'b1;
      if (hit[i]) begin
        if (whi) begin
          ent_d[i][63:32] = wdata;
        end else begin
          ent_d[i][31:0]  = wdata;
          ent_d[i][B_RP]  = 1'b0;
        end
      end
    end

    assign tbl[i*64 +: 64] = ent_q[i];

    // R7: a low-half write always leaves remote-pending cleared
    p_low_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !whi) |=> !ent_q[i][B_RP]);

    // R8: an edge-triggered entry never holds remote-pending
    p_edge_no_rp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_q[i][B_TRIG] |-> !ent_q[i][B_RP]);

    // R5: a high-half write leaves the low half untouched
    p_hi_keeps_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && whi && !rp_set[i]) |=> ent_q[i][31:0] == $past(ent_q[i][31:0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) ent_q[i] <= ENT_RESET;
    end else begin
      ent_q <= ent_d;
    end
  end

  logic mask_old;
  assign mask_old = ent_q[widx][B_MASK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_wr       <= 1'b0;
      ent_wr_pin   <= '0;
      mask_chg     <= 1'b0;
      mask_chg_pin <= '0;
      mask_chg_val <= 1'b0;
    end else begin
      ent_wr       <= we;
      ent_wr_pin   <= widx;
      mask_chg     <= we && !whi && (wdata[B_MASK] != mask_old);
      mask_chg_pin <= widx;
      mask_chg_val <= wdata[B_MASK];
    end
  end

  // R10: a mask change is always accompanied by an entry write
  p_mask_has_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg |-> ent_wr && (mask_chg_pin == ent_wr_pin));

  // R10: the reported value matches the stored mask
  p_mask_val_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg |-> ent_q[mask_chg_pin][B_MASK] == mask_chg_val);

endmodule

// File: rtl/irw_rdmux.sv
module irw_rdmux
  import irw_pkg::*;
#(
  parameter int         NPINS    = 24,
  parameter logic [7:0] VER_CODE = 8'h20,
  localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                rd,
  input  logic [7:0]          addr,
  input  logic [7:0]          sel_q,
  input  reg_kind_t           kind,
  input  logic [IDXW-1:0]     idx,
  input  logic                hi_half,
  input  logic [3:0]          id_q,
  input  logic [NPINS*64-1:0] tbl,
  output logic [31:0]         rdata
);

  logic [63:0] ent;
  logic [31:0] win;

  assign ent = tbl[idx*64 +: 64];

  always_comb begin
    unique case (kind)
      K_ID, K_ARB: win = id_word(id_q);
      K_VER:       win = ver_word(NPINS, VER_CODE);
      K_ENT:       win = hi_half ? ent[63:32] : ent[31:0];
      default:     win = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    rdata = 32'h0;
    if (rd) begin
      if (addr == OFS_SEL)      rdata = {24'h0, sel_q};
      else if (addr == OFS_WIN) rdata = win;
    end
  end

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irw_pkg::*;
#(
  parameter int         NPINS    = 24,
  parameter logic [7:0] VER_CODE = 8'h20,
  localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NPINS-1:0]    rp_set,
  output logic [NPINS*64-1:0] tbl_flat,
  output logic                ent_wr,
  output logic [IDXW-1:0]     ent_wr_pin,
  output logic                mask_chg,
  output logic [IDXW-1:0]     mask_chg_pin,
  output logic                mask_chg_val
);

  // named internal events
  logic            sel_we;
  logic            win_we;
  logic            id_we;
  logic            tbl_we;
  logic [7:0]      sel_q;
  reg_kind_t       kind;
  logic [IDXW-1:0] idx;
  logic            hi_half;
  logic [3:0]      id_q;

  assign sel_we = bus_wr && (bus_addr == OFS_SEL);
  assign win_we = bus_wr && (bus_addr == OFS_WIN);
  assign id_we  = win_we && (kind == K_ID);
  assign tbl_we = win_we && (kind == K_ENT);

  irw_select #(.NPINS(NPINS)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (sel_we),
    .sel_wbyte (bus_wdata[7:0]),
    .sel_q     (sel_q),
    .kind      (kind),
    .idx       (idx),
    .hi_half   (hi_half)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     id_q <= 4'h0;
    else if (id_we) id_q <= bus_wdata[27:24];
  end

  irw_table #(.NPINS(NPINS)) u_tbl (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (tbl_we),
    .widx         (idx),
    .whi          (hi_half),
    .wdata        (bus_wdata),
    .rp_set       (rp_set),
    .tbl          (tbl_flat),
    .ent_wr       (ent_wr),
    .ent_wr_pin   (ent_wr_pin),
    .mask_chg     (mask_chg),
    .mask_chg_pin (mask_chg_pin),
    .mask_chg_val (mask_chg_val)
  );

  irw_rdmux #(.NPINS(NPINS), .VER_CODE(VER_CODE)) u_rd (
    .rd      (bus_rd),
    .addr    (bus_addr),
    .sel_q   (sel_q),
    .kind    (kind),
    .idx     (idx),
    .hi_half (hi_half),
    .id_q    (id_q),
    .tbl     (tbl_flat),
    .rdata   (bus_rdata)
  );

  // R3/R4: the ID moves only on a window write with the ID select
  p_id_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !id_we |=> $stable(id_q));

  p_id_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    id_we |=> id_q == $past(bus_wdata[27:24]));

  // R6: writes through an invalid select raise no entry pulse
  p_oob_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && kind == K_BAD) |=> !ent_wr);

  // R11: every entry pulse follows an entry write one cycle earlier
  p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr |-> $past(tbl_we));

  // R12: a stray offset leaves the select unchanged
  p_stray_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFS_SEL && bus_addr != OFS_WIN) |=> $stable(sel_q));

endmodule

// File: tb/irq_regwin_test.sv
module irq_regwin_test;

  localparam int NPINS = 24;
  localparam int IDXW  = $clog2(NPINS);
  localparam logic [7:0] VER = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [NPINS-1:0] rp_set = '0;
  logic [NPINS*64-1:0] tbl_flat;
  logic ent_wr, mask_chg, mask_chg_val;
  logic [IDXW-1:0] ent_wr_pin, mask_chg_pin;

  always #5 clk = ~clk;

  irq_regwin #(.NPINS(NPINS), .VER_CODE(VER)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rp_set(rp_set), .tbl_flat(tbl_flat), .ent_wr(ent_wr),
    .ent_wr_pin(ent_wr_pin), .mask_chg(mask_chg),
    .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write: driven at a falling edge, captured at the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0000_0000, 8'd9},   // R9 select resets to 0
    '{1'b1, 8'h10, 32'h0000_0000, 8'd9},   // R9 ID resets to 0
    '{1'b0, 8'h00, 32'hABCD_1201, 8'd1},   // R1 only low byte kept
    '{1'b1, 8'h00, 32'h0000_0001, 8'd1},
    '{1'b1, 8'h10, 32'h0017_0020, 8'd2},   // R2 version word
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd2},
    '{1'b1, 8'h10, 32'h0017_0020, 8'd2},   // R2 write ignored
    '{1'b0, 8'h00, 32'h0000_0000, 8'd3},
    '{1'b0, 8'h10, 32'hF5FF_FFFF, 8'd3},   // R3 ID from bits 27:24
    '{1'b1, 8'h10, 32'h0500_0000, 8'd3},
    '{1'b0, 8'h00, 32'h0000_0002, 8'd4},
    '{1'b1, 8'h10, 32'h0500_0000, 8'd4},   // R4 arbitration mirrors ID
    '{1'b0, 8'h10, 32'h0A00_0000, 8'd4},
    '{1'b1, 8'h10, 32'h0500_0000, 8'd4},   // R4 write ignored
    '{1'b0, 8'h00, 32'h0000_0000, 8'd4},
    '{1'b1, 8'h10, 32'h0500_0000, 8'd4},   // R4 ID unchanged
    '{1'b0, 8'h00, 32'h0000_0010, 8'd9},
    '{1'b1, 8'h10, 32'h0001_0000, 8'd9},   // R9 entry 0 low: masked
    '{1'b0, 8'h00, 32'h0000_0011, 8'd9},
    '{1'b1, 8'h10, 32'h0000_0000, 8'd9},   // R9 entry 0 high
    '{1'b0, 8'h00, 32'h0000_0015, 8'd5},
    '{1'b0, 8'h10, 32'hAB00_0000, 8'd5},   // R5 pin 2 high half
    '{1'b1, 8'h10, 32'hAB00_0000, 8'd5},
    '{1'b0, 8'h00, 32'h0000_0014, 8'd5},
    '{1'b1, 8'h10, 32'h0001_0000, 8'd5},   // R5 low half untouched
    '{1'b0, 8'h10, 32'h0000_C031, 8'd7},   // R7 bit 14 written as 1
    '{1'b1, 8'h10, 32'h0000_8031, 8'd7},   // R7 stored as 0
    '{1'b0, 8'h00, 32'h0000_0040, 8'd6},   // R6 index 24, out of range
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 8'd6},
    '{1'b0, 8'h00, 32'h0000_0005, 8'd6},   // R6 reserved select
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 8'd6},
    '{1'b1, 8'h04, 32'h0000_0000, 8'd12},  // R12 stray offset reads 0
    '{1'b0, 8'h20, 32'h0000_0077, 8'd12},
    '{1'b1, 8'h00, 32'h0000_0005, 8'd12},  // R12 select unchanged
    '{1'b1, 8'h08, 32'h0000_0000, 8'd12}
  };

  bit done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] e2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ent_wr", {63'h0, ent_wr}, 64'h0);
    chk("R9 mask_chg", {63'h0, mask_chg}, 64'h0);
    chk("R9 pin 23 table", tbl_flat[23*64 +: 64], 64'h0000_0000_0001_0000);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].is_rd) begin
        rd(VEC[k].a, r);
        chk($sformatf("R%0d vector %0d", VEC[k].req, k), {32'h0, r}, {32'h0, VEC[k].d});
      end else begin
        wr(VEC[k].a, VEC[k].d);
      end
    end

    // R6: out-of-range write leaves table and pulses quiet
    wr(8'h00, 8'h40);
    wr(8'h10, 32'h1234_5678);
    chk("R6 no ent_wr", {63'h0, ent_wr}, 64'h0);

    // R5: last pin, high half, and export to the table port
    wr(8'h00, 32'h3F);
    wr(8'h10, 32'h0000_0001);
    chk("R11 ent_wr last pin", {63'h0, ent_wr}, 64'h1);
    chk("R11 ent_wr_pin", {59'h0, ent_wr_pin}, 64'd23);
    chk("R5 pin 23 exported", tbl_flat[23*64 +: 64], 64'h0000_0001_0001_0000);
    chk("R5 pin 2 exported", tbl_flat[2*64 +: 64], 64'hAB00_0000_0000_8031);

    // R8: level pin 2 gets remote-pending from rp_set
    @(negedge clk); rp_set[2] = 1'b1;
    @(negedge clk); rp_set[2] = 1'b0;
    wr(8'h00, 32'h14);
    rd(8'h10, r);
    chk("R8 level rp set", {32'h0, r}, 64'h0000_C031);
    // R7: high-half write keeps the flag
    wr(8'h00, 32'h15);
    wr(8'h10, 32'hCD00_0000);
    wr(8'h00, 32'h14);
    rd(8'h10, r);
    chk("R7 high write keeps rp", {32'h0, r}, 64'h0000_C031);
    // R8: same-cycle rp_set and low write: write wins
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_8031; rp_set[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rp_set[2] = 1'b0;
    chk("R10 no mask change", {63'h0, mask_chg}, 64'h0);
    rd(8'h10, r);
    chk("R8 write beats rp_set", {32'h0, r}, 64'h0000_8031);

    // R10: unmask pin 0 (edge)
    wr(8'h00, 32'h10);
    wr(8'h10, 32'h0000_0040);
    chk("R10 mask_chg", {63'h0, mask_chg}, 64'h1);
    chk("R10 mask_chg_pin", {59'h0, mask_chg_pin}, 64'd0);
    chk("R10 mask_chg_val", {63'h0, mask_chg_val}, 64'h0);
    @(negedge clk);
    chk("R10 one cycle", {63'h0, mask_chg}, 64'h0);
    // R8: edge entry ignores rp_set
    @(negedge clk); rp_set[0] = 1'b1;
    @(negedge clk); rp_set[0] = 1'b0;
    rd(8'h10, r);
    chk("R8 edge ignores rp_set", {32'h0, r}, 64'h0000_0040);
    // R10/R11: rewrite with same mask
    wr(8'h10, 32'h0000_0041);
    chk("R11 ent_wr pin 0", {63'h0, ent_wr}, 64'h1);
    chk("R10 unchanged mask", {63'h0, mask_chg}, 64'h0);
    // R10: remask pin 0
    wr(8'h10, 32'h0001_0041);
    chk("R10 remask val", {63'h0, mask_chg_val}, 64'h1);
    e2 = tbl_flat[0 +: 64];
    chk("R5 pin 0 exported", e2, 64'h0000_0000_0001_0041);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule